// File: doc/BRIEF.md
# Smart Card Character Transmitter

This block sends characters to a smart card over one shared open-drain I/O line. The host writes a byte to load it. The block then sends a start bit, the eight data bits least significant first, and an even parity bit. Each bit lasts one elementary time unit (etu), and one etu is a parameterised number of clock cycles. After the parity bit the block releases the line for the guard time and samples it once, in the middle of the eleventh etu. A card that received a bad parity pulls the line low at that point. When the block sees this, it sets a sticky error flag, waits until the card has released the line and a further two etu have passed, and then sends the same character again without any help from the host.

The host learns that a character has finished from the transmit-end flag. A mode input selects when that flag rises: 12.5 etu after the start edge in standard mode, or 11.0 etu in early mode. Two level interrupt requests report transmit-end and error, each behind its own enable. Dropping the enable input aborts a character in progress and releases the line.

Top module: `sc_char_tx`

## Requirements
- R1: After reset the line is released (`line_drive_low`=0), `tx_empty`=1, `tx_end`=1, `tx_err`=0 and both interrupt requests are 0.
- R2: A `wr_stb` pulse is accepted only when `tx_en`=1, `tx_end`=1 and `tx_err`=0. On acceptance `tx_empty` and `tx_end` drop on the next cycle and the start bit begins on the cycle after that.
- R3: A character is ten bits of ETU_CYCLES clocks each: a start bit of 0, `wr_data` bits 0 to 7 in that order, then a bit equal to the XOR of the eight data bits. A 0 bit is sent as `line_drive_low`=1 and a 1 bit as `line_drive_low`=0.
- R4: From 10.0 etu after the start edge the line is released. The line is sampled at 10.5 etu, and if it is low then `tx_err` becomes 1.
- R5: After an error the line stays released. The same character is sent again when `line_in` has been high for 2 etu (the start edge follows ETU_CYCLES*2+1 negative clock edges after the release), and `tx_end` stays 0 meanwhile.
- R6: For a character with no error, `tx_end` and `tx_empty` rise 12.5 etu after the start edge when `etu_mode`=0 and 11.0 etu after it when `etu_mode`=1.
- R7: `irq_tx_empty` equals `tie` AND `tx_end`, and `irq_tx_err` equals `rie` AND `tx_err`, each one clock later.
- R8: A write while `tx_err`=1 or while a character is in progress is ignored: no character starts and the character on the line is unchanged.
- R9: An `err_clr` pulse clears `tx_err`.
- R10: When `tx_en` is 0 the line is released on the next clock and `tx_end` and `tx_empty` become 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable; 0 aborts and idles |
| etu_mode | input | 1 | 0: end flag at 12.5 etu, 1: at 11.0 etu |
| wr_stb | input | 1 | Load strobe for `wr_data` |
| wr_data | input | 8 | Character to send |
| err_clr | input | 1 | Clears the error flag |
| tie | input | 1 | Transmit-end interrupt enable |
| rie | input | 1 | Error interrupt enable |
| line_in | input | 1 | Sensed level of the I/O line |
| line_drive_low | output | 1 | 1 pulls the line low, 0 releases it |
| tx_empty | output | 1 | Data register empty |
| tx_end | output | 1 | Transmission complete |
| tx_err | output | 1 | Error signal seen (sticky) |
| irq_tx_empty | output | 1 | Transmit-end interrupt request |
| irq_tx_err | output | 1 | Error interrupt request |

## Verification
The bench sends all 256 byte values and switches the end-flag mode between characters. This exposes any bit-order, parity or bit-length fault, and it tells the 11.0 etu end point from the 12.5 etu one to the exact cycle. A subset of characters gets one or two error pulses from a card model. These show that the error is sampled inside the guard time, that the retransmitted character is the same one, and that the gap after the line is released is exact. Writes made while the error flag is set or in the middle of a frame, together with an abort by the enable, tell whether the acceptance gating and the abort path work.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FRAME,
    ST_ERRWAIT
  } seq_state_e;

  // positions counted in half-etu steps from the start edge
  localparam int FRAME_BITS   = 10;
  localparam int HP_GUARD     = 2 * FRAME_BITS;
  localparam int HP_SAMPLE    = HP_GUARD + 1;
  localparam int HP_END_EARLY = 22;
  localparam int HP_END_STD   = 25;
  localparam int GAP_HALVES   = 4;
  localparam int POS_W        = 5;
  localparam int GAP_W        = 3;
endpackage

// File: rtl/sc_etu_div.sv
module sc_etu_div #(
  parameter int HALF_CYC = 186
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = run && !clr && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || !run) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_div_range_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/sc_tx_seq.sv
module sc_tx_seq
  import sc_tx_pkg::*;
#(
  parameter int HALF_CYC = 186
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       start,
  input  logic [7:0] data,
  input  logic       early_end,
  input  logic       line_in,
  output logic       drive_low,
  output logic       done,
  output logic       err
);
  seq_state_e             state;
  logic [POS_W-1:0]       pos;
  logic [POS_W-1:0]       pos_nx;
  logic [GAP_W-1:0]       gap;
  logic [FRAME_BITS-1:0]  frm;
  logic                   tick;
  logic                   div_clr;
  logic                   relaunch;
  logic [POS_W-1:0]       end_pos;
  logic [3:0]             bit_idx;
  logic                   bit_val;

  assign pos_nx   = pos + 1'b1;
  assign end_pos  = early_end ? POS_W'(HP_END_EARLY) : POS_W'(HP_END_STD);
  assign relaunch = (state == ST_ERRWAIT) && line_in && (gap == GAP_W'(GAP_HALVES));
  assign div_clr  = (state == ST_IDLE) || relaunch ||
                    ((state == ST_ERRWAIT) && !line_in);
  assign bit_idx  = pos_nx[4:1];
  assign bit_val  = (bit_idx < 4'(FRAME_BITS)) ? frm[bit_idx] : 1'b1;

  sc_etu_div #(.HALF_CYC(HALF_CYC)) u_div (
    .clk  (clk),
    .rst  (rst),
    .clr  (div_clr),
    .run  (state != ST_IDLE),
    .tick (tick)
  );

  assign done = en && (state == ST_FRAME) && tick && (pos_nx == end_pos);
  assign err  = en && (state == ST_FRAME) && tick &&
                (pos_nx == POS_W'(HP_SAMPLE)) && !line_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pos       <= '0;
      gap       <= '0;
      frm       <= '0;
      drive_low <= 1'b0;
    end else if (!en) begin
      state     <= ST_IDLE;
      pos       <= '0;
      gap       <= '0;
      drive_low <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            frm       <= {^data, data, 1'b0};
            pos       <= '0;
            drive_low <= 1'b1;
            state     <= ST_FRAME;
          end
        end
        ST_FRAME: begin
          if (tick) begin
            pos <= pos_nx;
            if (pos_nx < POS_W'(HP_GUARD)) begin
              drive_low <= ~bit_val;
            end else begin
              drive_low <= 1'b0;
            end
            if (err) begin
              gap   <= '0;
              state <= ST_ERRWAIT;
            end else if (done) begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ERRWAIT: begin
          if (!line_in) begin
            gap <= '0;
          end else if (relaunch) begin
            pos       <= '0;
            gap       <= '0;
            drive_low <= 1'b1;
            state     <= ST_FRAME;
          end else if (tick) begin
            gap <= gap + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_guard_release_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FRAME && pos >= POS_W'(HP_GUARD)) |-> !drive_low);

  assert_errwait_release_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ERRWAIT) |-> !drive_low);

  assert_start_bit_low_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FRAME && pos == '0) |-> drive_low);

  assert_done_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
endmodule

// File: rtl/sc_tx_host.sv
module sc_tx_host (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       wr,
  input  logic [7:0] wr_byte,
  input  logic       err_clr,
  input  logic       tie,
  input  logic       rie,
  input  logic       done,
  input  logic       err,
  output logic [7:0] data_q,
  output logic       start_q,
  output logic       empty_q,
  output logic       end_q,
  output logic       err_q,
  output logic       irq_end_q,
  output logic       irq_err_q
);
  logic accept;

  assign accept = wr && en && end_q && !err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q    <= '0;
      start_q   <= 1'b0;
      empty_q   <= 1'b1;
      end_q     <= 1'b1;
      err_q     <= 1'b0;
      irq_end_q <= 1'b0;
      irq_err_q <= 1'b0;
    end else begin
      start_q <= accept;
      if (accept) begin
        data_q  <= wr_byte;
        empty_q <= 1'b0;
        end_q   <= 1'b0;
      end else if (done || !en) begin
        empty_q <= 1'b1;
        end_q   <= 1'b1;
      end
      if (err) begin
        err_q <= 1'b1;
      end else if (err_clr) begin
        err_q <= 1'b0;
      end
      irq_end_q <= tie && end_q;
      irq_err_q <= rie && err_q;
    end
  end

  assert_load_clears_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!end_q && !empty_q && start_q));

  assert_ignored_write_R8: assert property (@(posedge clk) disable iff (rst)
    (wr && (err_q || !end_q)) |=> $stable(data_q));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (err_q && !err_clr) |=> err_q);

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
    irq_end_q |-> $past(tie));
endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx #(
  parameter int ETU_CYCLES = 372
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_en,
  input  logic       etu_mode,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  input  logic       err_clr,
  input  logic       tie,
  input  logic       rie,
  input  logic       line_in,
  output logic       line_drive_low,
  output logic       tx_empty,
  output logic       tx_end,
  output logic       tx_err,
  output logic       irq_tx_empty,
  output logic       irq_tx_err
);
  localparam int HALF_CYC = ETU_CYCLES / 2;

  logic [7:0] data_q;
  logic       start_q;
  logic       done;
  logic       err;

  sc_tx_host u_host (
    .clk       (clk),
    .rst       (rst),
    .en        (tx_en),
    .wr        (wr_stb),
    .wr_byte   (wr_data),
    .err_clr   (err_clr),
    .tie       (tie),
    .rie       (rie),
    .done      (done),
    .err       (err),
    .data_q    (data_q),
    .start_q   (start_q),
    .empty_q   (tx_empty),
    .end_q     (tx_end),
    .err_q     (tx_err),
    .irq_end_q (irq_tx_empty),
    .irq_err_q (irq_tx_err)
  );

  sc_tx_seq #(.HALF_CYC(HALF_CYC)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .en        (tx_en),
    .start     (start_q),
    .data      (data_q),
    .early_end (etu_mode),
    .line_in   (line_in),
    .drive_low (line_drive_low),
    .done      (done),
    .err       (err)
  );

  assert_disable_release_R10: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (!line_drive_low && tx_end));
endmodule

// File: tb/tb_sc_char_tx.sv
module tb_sc_char_tx;
  localparam int CLK_PERIOD = 10;
  localparam int ETU = 8;
  localparam int H = ETU / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0, etu_mode = 1'b0, wr_stb = 1'b0, err_clr = 1'b0;
  logic tie = 1'b0, rie = 1'b0, card_low = 1'b0;
  logic [7:0] wr_data = '0;
  logic line_drive_low, tx_empty, tx_end, tx_err, irq_tx_empty, irq_tx_err;
  logic line_in;

  int n_chk = 0, n_fail = 0, cyc = 0;

  assign line_in = !(line_drive_low || card_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_char_tx #(.ETU_CYCLES(ETU)) dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .etu_mode(etu_mode),
    .wr_stb(wr_stb), .wr_data(wr_data), .err_clr(err_clr),
    .tie(tie), .rie(rie), .line_in(line_in),
    .line_drive_low(line_drive_low), .tx_empty(tx_empty), .tx_end(tx_end),
    .tx_err(tx_err), .irq_tx_empty(irq_tx_empty), .irq_tx_err(irq_tx_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      finish_run();
    end
  end

  // send one byte; the card model flags nerr errors before accepting it
  task automatic send_char(input logic [7:0] b, input logic mode, input int nerr,
                           input bit poke);
    int t;
    etu_mode = mode;
    @(negedge clk); wr_stb = 1'b1; wr_data = b;
    @(negedge clk); wr_stb = 1'b0;
    chk(!tx_end && !tx_empty, "R2 flags cleared on load", tx_end, 0);
    t = 0;
    while (!line_drive_low && t < 50) begin @(negedge clk); t++; end
    chk(line_drive_low == 1'b1, "R2 start bit begins", t, 1);
    for (int f = 0; f <= nerr; f++) begin
      logic [9:0] seen = '0;
      int tend_k = -1;
      bit err_f = (f < nerr);
      for (int k = 0; k <= 26*H; k++) begin
        for (int bi = 0; bi < 10; bi++)
          if (k == 2*bi*H + H) seen[bi] = !line_drive_low;
        if (poke && f == 0 && k == 5*H) begin wr_stb = 1'b1; wr_data = ~b; end
        if (poke && f == 0 && k == 5*H + 1) wr_stb = 1'b0;
        if (k == 10*H) chk(irq_tx_empty == 1'b0, "R7 no end irq mid-frame", irq_tx_empty, 0);
        if (k == 20*H) chk(!line_drive_low, "R4 guard time released", line_drive_low, 0);
        if (k == 20*H + 1 && err_f) card_low = 1'b1;
        if (k == 21*H + 1)
          chk(tx_err == (err_f || f > 0), "R4 error flag at sample", tx_err, int'(err_f || f > 0));
        if (k == 21*H + 2 && err_f)
          chk(irq_tx_err == rie, "R7 error irq follows enable", irq_tx_err, rie);
        if (!err_f && tend_k < 0 && tx_end) tend_k = k;
        if (err_f && k == 22*H + 1) break;
        @(negedge clk);
      end
      chk(seen[0] == 1'b0, "R3 start bit", seen[0], 0);
      chk(seen[8:1] == b, "R3 data bits lsb first", seen[8:1], b);
      chk(seen[9] == ^b, "R3 even parity", seen[9], ^b);
      if (err_f) begin
        int g = 0;
        card_low = 1'b0;
        do begin @(negedge clk); g++; end while (!line_drive_low && g < 20*H);
        chk(g == 4*H + 1, "R5 retransmit gap", g, 4*H + 1);
        chk(tx_end == 1'b0, "R5 end flag held during retry", tx_end, 0);
      end else begin
        chk(tend_k == (mode ? 22*H : 25*H), "R6 end flag timing", tend_k, mode ? 22*H : 25*H);
        chk(tx_empty == 1'b1, "R6 empty flag set", tx_empty, 1);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!line_drive_low && tx_empty && tx_end && !tx_err && !irq_tx_empty && !irq_tx_err,
        "R1 reset state", {line_drive_low, tx_empty, tx_end, tx_err}, 4'b0110);
    rst = 1'b0;
    tx_en = 1'b1;
    for (int i = 0; i < 256; i++) begin
      int nerr = (i % 37 == 5) ? 1 : ((i % 53 == 7) ? 2 : 0);
      tie = i[1];
      rie = !i[2];
      send_char(8'(i), i[0], nerr, (i % 29 == 3));
      repeat (2) @(negedge clk);
      chk(irq_tx_empty == tie, "R7 end irq follows enable", irq_tx_empty, tie);
      if (nerr > 0) begin
        bit started = 0;
        @(negedge clk); wr_stb = 1'b1; wr_data = 8'h00;
        @(negedge clk); wr_stb = 1'b0;
        for (int k = 0; k < 3*ETU; k++) begin
          if (line_drive_low) started = 1;
          @(negedge clk);
        end
        chk(!started && tx_end, "R8 write ignored while error set", started, 0);
        err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        @(negedge clk);
        chk(tx_err == 1'b0, "R9 error flag cleared", tx_err, 0);
      end
    end
    // abort by disabling mid-character
    @(negedge clk); wr_stb = 1'b1; wr_data = 8'h00;
    @(negedge clk); wr_stb = 1'b0;
    repeat (3*ETU) @(negedge clk);
    chk(line_drive_low == 1'b1, "R10 frame running before abort", line_drive_low, 1);
    tx_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!line_drive_low && tx_end && tx_empty, "R10 abort releases line",
        {line_drive_low, tx_end, tx_empty}, 3'b011);
    @(negedge clk); wr_stb = 1'b1; wr_data = 8'h00;
    @(negedge clk); wr_stb = 1'b0;
    repeat (ETU) @(negedge clk);
    chk(!line_drive_low, "R8 write ignored while disabled", line_drive_low, 0);
    tx_en = 1'b1;
    send_char(8'hA5, 1'b0, 0, 0);
    finish_run();
  end
endmodule